// File: doc/BRIEF.md
# Persistent Configuration Store and Reload Controller

This block keeps a small bank of configuration registers and backs a chosen subset of their bits with a nonvolatile storage array. The storage is modelled as an internal register array, and each operation on it takes a fixed number of clock cycles. A host reaches the registers through a plain write strobe and a plain read strobe. It starts storage operations by writing a command word to a dedicated trigger address.

There are two storage operations. A program operation copies every persistent bit of the registers into storage. A reload operation copies the stored persistent bits back into the registers. The block runs a reload by itself when it leaves reset, so the registers start from the stored image. For the whole of any storage operation, busy is high and the host port is locked out.

Top module: `nvm_shadow_ctrl`

## Requirements
- R1: While reset is held, and for RELOAD_CYC clock cycles after it is released, busy is high. After that, every persistent bit of each register equals the stored image (initial content NVM_INIT), and every bit outside PERSIST_MASK reads 0.
- R2: When busy is low, a host write to register address i (i < NREG) sets that whole register. Every read strobe produces rd_valid one cycle later, and rd_data then carries the addressed register.
- R3: Writing a word with bit 0 set to the trigger address (all-ones address) while idle starts a program operation. Busy stays high for exactly PROG_CYC cycles. Storage then holds the register contents ANDed with PERSIST_MASK, and storage changes at no other time.
- R4: Writing a word with bit 1 set and bit 0 clear to the trigger address while idle starts a reload. Busy stays high for exactly RELOAD_CYC cycles. Afterwards every persistent bit equals storage.
- R5: The trigger register clears itself. A read of the trigger address made while idle returns 0.
- R6: A host write that arrives while busy is high is discarded, and the register contents stay unchanged through a program operation.
- R7: A host read that arrives while busy is high still produces rd_valid, and its rd_data is 0.
- R8: If one trigger write sets both bit 0 and bit 1, only the program operation runs, lasting PROG_CYC cycles.
- R9: A trigger write made during a running operation is ignored. The running operation ends at its original time and no new operation follows it.
- R4b: A reload leaves the bits outside PERSIST_MASK at their current values.
- R10: Writes to addresses that are neither a register nor the trigger address change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset (power-on) |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address; all-ones selects the trigger register |
| wr_data | input | DW | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| rd_data | output | DW | Read response data |
| busy | output | 1 | High while a program or reload operation runs |

## Verification
The assertions assume that a read strobe lasts one cycle and gets its response on the next cycle, with no back-pressure, since the host port never stalls. They also assume that reset is held for at least one clock edge before any access. The stimulus drives every strobe for a single cycle, placed between clock edges. It holds reset for several cycles. It issues the blocked accesses and the blocked trigger write only inside the busy window, and it counts the busy cycles they consume.

// File: rtl/nvm_shadow_pkg.sv
package nvm_shadow_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_LOAD = 2'd2
  } op_e;

  // Trigger word bit positions
  localparam int unsigned TRIG_PROG_BIT = 0;
  localparam int unsigned TRIG_LOAD_BIT = 1;
endpackage

// File: rtl/nvm_op_timer.sv
module nvm_op_timer
  import nvm_shadow_pkg::*;
#(
  parameter int unsigned PROG_CYC   = 20,
  parameter int unsigned RELOAD_CYC = 6,
  localparam int unsigned MAXC = (PROG_CYC > RELOAD_CYC) ? PROG_CYC : RELOAD_CYC,
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_load,
  output op_e           op,
  output logic [CW-1:0] cnt,
  output logic          commit_prog,
  output logic          commit_load
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op  <= OP_LOAD;
      cnt <= CW'(RELOAD_CYC - 1);
    end else begin
      case (op)
        OP_IDLE: begin
          if (start_prog) begin
            op  <= OP_PROG;
            cnt <= CW'(PROG_CYC - 1);
          end else if (start_load) begin
            op  <= OP_LOAD;
            cnt <= CW'(RELOAD_CYC - 1);
          end
        end
        OP_PROG, OP_LOAD: begin
          if (cnt == '0) op <= OP_IDLE;
          else           cnt <= cnt - CW'(1);
        end
        default: op <= OP_IDLE;
      endcase
    end
  end

  assign commit_prog = (op == OP_PROG) && (cnt == '0);
  assign commit_load = (op == OP_LOAD) && (cnt == '0);
endmodule

// File: rtl/nvm_store_array.sv
module nvm_store_array #(
  parameter int unsigned      NREG         = 4,
  parameter int unsigned      DW           = 8,
  parameter logic [NREG*DW-1:0] NVM_INIT     = '0,
  parameter logic [NREG*DW-1:0] PERSIST_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [NREG*DW-1:0] shadow_flat,
  output logic [NREG*DW-1:0] store_flat
);
  // Reset stands for the factory image present at power-on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_flat <= NVM_INIT;
    else if (commit) store_flat <= shadow_flat & PERSIST_MASK;
  end
endmodule

// File: rtl/nvm_shadow_bank.sv
module nvm_shadow_bank #(
  parameter int unsigned        NREG         = 4,
  parameter int unsigned        DW           = 8,
  parameter int unsigned        AW           = 3,
  parameter logic [NREG*DW-1:0] PERSIST_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               load,
  input  logic [NREG*DW-1:0] store_flat,
  input  logic [AW-1:0]      rd_addr,
  output logic [NREG*DW-1:0] reg_flat,
  output logic [DW-1:0]      rd_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_flat <= '0;
    end else if (load) begin
      reg_flat <= (reg_flat & ~PERSIST_MASK) | (store_flat & PERSIST_MASK);
    end else if (wr_ok) begin
      for (int i = 0; i < int'(NREG); i++)
        if (wr_addr == AW'(i)) reg_flat[i*DW +: DW] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(NREG); i++)
      if (rd_addr == AW'(i)) rd_word = reg_flat[i*DW +: DW];
  end
endmodule

// File: rtl/nvm_shadow_ctrl.sv
module nvm_shadow_ctrl
  import nvm_shadow_pkg::*;
#(
  parameter int unsigned        NREG         = 4,
  parameter int unsigned        DW           = 8,
  parameter int unsigned        AW           = 3,
  parameter int unsigned        PROG_CYC     = 20,
  parameter int unsigned        RELOAD_CYC   = 6,
  parameter logic [NREG*DW-1:0] NVM_INIT     = 32'hA53C_96E1,
  parameter logic [NREG*DW-1:0] PERSIST_MASK = 32'h0FFF_7FF0,
  localparam int unsigned MAXC = (PROG_CYC > RELOAD_CYC) ? PROG_CYC : RELOAD_CYC,
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam logic [AW-1:0] TRIG_ADDR = '1;

  op_e               op;
  logic [CW-1:0]     cnt;
  logic              commit_prog, commit_load;
  logic              idle, trig_wr, start_prog, start_load;
  logic [NREG*DW-1:0] reg_flat, store_flat;
  logic [DW-1:0]     rd_word;

  assign idle       = (op == OP_IDLE);
  assign busy       = !idle;
  assign trig_wr    = wr_en && idle && (wr_addr == TRIG_ADDR);
  assign start_prog = trig_wr && wr_data[TRIG_PROG_BIT];
  assign start_load = trig_wr && wr_data[TRIG_LOAD_BIT] && !wr_data[TRIG_PROG_BIT];

  nvm_op_timer #(.PROG_CYC(PROG_CYC), .RELOAD_CYC(RELOAD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_load(start_load),
    .op(op), .cnt(cnt), .commit_prog(commit_prog), .commit_load(commit_load)
  );

  nvm_store_array #(.NREG(NREG), .DW(DW), .NVM_INIT(NVM_INIT),
                    .PERSIST_MASK(PERSIST_MASK)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_prog),
    .shadow_flat(reg_flat), .store_flat(store_flat)
  );

  nvm_shadow_bank #(.NREG(NREG), .DW(DW), .AW(AW),
                    .PERSIST_MASK(PERSIST_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_en && idle), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(commit_load), .store_flat(store_flat),
    .rd_addr(rd_addr), .reg_flat(reg_flat), .rd_word(rd_word)
  );

  // Trigger bits clear themselves, so the trigger address reads as zero when idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && idle) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/nvm_shadow_chk.sv
module nvm_shadow_chk
  import nvm_shadow_pkg::*;
#(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               rd_valid,
  input logic [DW-1:0]      rd_data,
  input logic               busy,
  input op_e                op,
  input logic [CW-1:0]      cnt,
  input logic [NREG*DW-1:0] reg_flat,
  input logic [NREG*DW-1:0] store_flat
);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R7
  blocked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data == '0));

  // R6
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROG) |=> $stable(reg_flat));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1)));

  // R3
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_PROG) |=> $stable(store_flat));
endmodule

bind nvm_shadow_ctrl nvm_shadow_chk #(.NREG(NREG), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .busy(busy), .op(op), .cnt(cnt),
  .reg_flat(reg_flat), .store_flat(store_flat)
);

// File: tb/sim_nvm_shadow_ctrl.sv
module sim_nvm_shadow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 20;
  localparam int RELOAD_CYC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_valid, busy;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_shadow_ctrl #(.PROG_CYC(PROG_CYC), .RELOAD_CYC(RELOAD_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: push the expected response, then issue the read
  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic busy_len(int start, int exp, string tag);
    int n = start;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  // Monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    busy_len(0, RELOAD_CYC, "R1 reset load length");
    rd(0, 8'hE0, "R1 reg0"); rd(1, 8'h16, "R1 reg1");
    rd(2, 8'h3C, "R1 reg2"); rd(3, 8'h05, "R1 reg3");
    rd(7, 8'h00, "R5 trigger idle");

    wr(0, 8'h5A); wr(1, 8'hFF); wr(2, 8'h12); wr(3, 8'hC3);
    rd(0, 8'h5A, "R2 reg0"); rd(1, 8'hFF, "R2 reg1");
    rd(2, 8'h12, "R2 reg2"); rd(3, 8'hC3, "R2 reg3");
    wr(5, 8'h77);
    rd(5, 8'h00, "R10 unused read"); rd(3, 8'hC3, "R10 reg3 untouched");

    // program, with blocked accesses inside the window
    wr(7, 8'h01);
    wr(1, 8'h00);               // R6 blocked write
    wr(7, 8'h02);               // R9 blocked trigger
    rd(0, 8'h00, "R7 blocked read");
    busy_len(3, PROG_CYC, "R3 R9 program length");
    rd(1, 8'hFF, "R6 write discarded");
    rd(7, 8'h00, "R5 trigger cleared");

    // reload restores persistent bits, keeps the others
    wr(0, 8'h0F); wr(1, 8'h80); wr(2, 8'h00); wr(3, 8'hF0);
    wr(7, 8'h02);
    busy_len(0, RELOAD_CYC, "R4 reload length");
    rd(0, 8'h5F, "R4b reg0"); rd(1, 8'hFF, "R4b reg1");
    rd(2, 8'h12, "R4 reg2");  rd(3, 8'hF3, "R4b reg3");

    // both bits set: program only
    wr(2, 8'h99);
    wr(7, 8'h03);
    busy_len(0, PROG_CYC, "R8 both bits length");
    wr(2, 8'h00);
    wr(7, 8'h02);
    busy_len(0, RELOAD_CYC, "R4 second reload");
    rd(2, 8'h99, "R8 program took effect");
    rd(0, 8'h5F, "R3 persistent reg0");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 responses drained", exp_q.size(), 0);
    finish_run();
  end
endmodule